// File: doc/BRIEF.md
# Two-phase predicated vector gather

This block performs an indexed vector load in two separate operations that share a small file of eight gather registers. A post operation takes a 32-bit scalar base, sixteen 32-bit lane offsets, a 16-bit lane predicate and a gather-register index. It zeroes the chosen gather register and then steps through the lanes in order, one per cycle, from lane 0 to lane 15. For every active lane it reads the word at base plus offset from an internal synchronous RAM and stores it in that lane. While this runs the block holds `busy` high, and it pulses `post_done` once the last lane has been written.

A drain operation, issued at any later time, names one gather register and returns its sixteen staged lanes on `drain_vec` one cycle later. It can return them as they are, with the low byte of each lane sign-extended, or packed as 8-bit elements into one half of a double-rate destination. The RAM is filled through a plain write port. The predicate is produced by logic outside this block.

Top module: `gth_gather_top`

## Requirements
- R1: There are eight gather registers, selected by a 3-bit index. A post changes only the register it names, and a drain of any other register returns that register's own contents.
- R2: The address of lane k is `post_base + post_offs[32k+31:32k]`, taken modulo 2^32. Its low MEM_AW bits (8 by default) select the 32-bit RAM word.
- R3: For every active lane, the lane of the gather register receives the RAM word at that lane's address.
- R4: A lane whose predicate bit is 0 is not read from memory. It holds zero after the post, even if the register held data before.
- R5: When `post_pred_en` is 0 (the non-predicated form), all sixteen lanes are active whatever `post_pred` holds.
- R6: A drain with mode 0 (full) sets `drain_vld` for one cycle on the cycle after `drain_valid`. In that cycle `drain_vec[32k+31:32k]` holds lane k of the named register.
- R7: A drain with mode 1 returns each lane as the sign extension of its low 8 bits.
- R8: Modes 2 and 3 treat the destination as 32 elements of 16 bits. Element k (mode 2) or element 16+k (mode 3) receives the zero-extended low byte of lane k, and every other element is zero.
- R9: A post is accepted on a clock edge where `post_valid` is high and `busy` is low. `busy` is then high for exactly 17 cycles. `post_done` is high for one cycle, the first cycle in which `busy` is low again.
- R10: A `post_valid` while `busy` is high is ignored. It changes no gather register and does not lengthen the running post.
- R11: After reset, `busy`, `post_done` and `drain_vld` are low and all gather registers read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_we | input | 1 | RAM write enable |
| mem_waddr | input | MEM_AW | RAM write word address |
| mem_wdata | input | 32 | RAM write data |
| post_valid | input | 1 | Start a post operation |
| post_pred_en | input | 1 | 1 = predicated form, 0 = all lanes active |
| post_base | input | 32 | Scalar base address |
| post_offs | input | 512 | Sixteen 32-bit lane offsets, lane k at bits 32k+31:32k |
| post_pred | input | 16 | Lane predicate, bit k for lane k |
| post_gr | input | 3 | Target gather register |
| busy | output | 1 | Post in progress |
| post_done | output | 1 | One-cycle pulse when the target register is complete |
| drain_valid | input | 1 | Start a drain |
| drain_gr | input | 3 | Source gather register |
| drain_mode | input | 2 | 0 full, 1 sign-extend byte, 2 dual low half, 3 dual high half |
| drain_vec | output | 512 | Drained vector |
| drain_vld | output | 1 | `drain_vec` is valid |

## Verification
A wrong lane counter or a stuck predicate mask does not show on `busy`. It shows only as wrong or non-zero lanes when the register is drained. That drain can come many cycles after the post, so every post is followed by a drain that compares all sixteen lanes with a bench model. A bad index decode corrupts a register other than the one posted, and drains of untouched registers catch that. Sequencing faults do show at once: `busy` runs one cycle too long or too short, or `post_done` comes too early or repeats, and these are checked on the cycle they happen.

// File: rtl/gth_pkg.sv
package gth_pkg;

    localparam int LANES      = 16;
    localparam int LANE_W     = 32;
    localparam int NUM_GR     = 8;
    localparam int GR_IDX_W   = $clog2(NUM_GR);
    localparam int LANE_IDX_W = $clog2(LANES);
    localparam int VEC_W      = LANES * LANE_W;
    localparam int HALF_W     = 16;

    typedef logic [LANES-1:0][LANE_W-1:0] lanes_t;

    typedef enum logic [1:0] {
        DR_FULL    = 2'd0,
        DR_SX8     = 2'd1,
        DR_DUAL_LO = 2'd2,
        DR_DUAL_HI = 2'd3
    } drain_mode_e;

    // Each predicate bit becomes a full-width lane mask.
    function automatic lanes_t expand_pred(input logic [LANES-1:0] p);
        lanes_t m;
        for (int k = 0; k < LANES; k++) m[k] = {LANE_W{p[k]}};
        return m;
    endfunction

    function automatic logic [LANE_W-1:0] lane_addr(input logic [LANE_W-1:0] base,
                                                    input logic [LANE_W-1:0] off);
        return base + off;
    endfunction

    function automatic logic [VEC_W-1:0] format_drain(input lanes_t g, input drain_mode_e m);
        logic [VEC_W-1:0] v;
        v = '0;
        case (m)
            DR_FULL: v = g;
            DR_SX8: begin
                for (int k = 0; k < LANES; k++)
                    v[k*LANE_W +: LANE_W] = {{(LANE_W-8){g[k][7]}}, g[k][7:0]};
            end
            DR_DUAL_LO: begin
                for (int k = 0; k < LANES; k++)
                    v[k*HALF_W +: HALF_W] = {8'h00, g[k][7:0]};
            end
            default: begin
                for (int k = 0; k < LANES; k++)
                    v[(LANES+k)*HALF_W +: HALF_W] = {8'h00, g[k][7:0]};
            end
        endcase
        return v;
    endfunction

endpackage

// File: rtl/gth_ram.sv
module gth_ram #(
    parameter int AW = 8,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem_q[waddr] <= wdata;
        if (re) rdata <= mem_q[raddr];
    end
endmodule

// File: rtl/gth_seq.sv
module gth_seq
    import gth_pkg::*;
#(
    parameter int MEM_AW = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  post_valid,
    input  logic                  post_pred_en,
    input  logic [LANE_W-1:0]     post_base,
    input  lanes_t                post_offs,
    input  logic [LANES-1:0]      post_pred,
    input  logic [GR_IDX_W-1:0]   post_gr,
    output logic                  busy,
    output logic                  post_done,
    output logic                  ram_re,
    output logic [MEM_AW-1:0]     ram_raddr,
    output logic                  clr_en,
    output logic [GR_IDX_W-1:0]   clr_idx,
    output logic                  lane_we,
    output logic [GR_IDX_W-1:0]   lane_gr,
    output logic [LANE_IDX_W-1:0] lane_idx
);
    logic                  walking_q;
    logic [LANE_IDX_W-1:0] ctr_q;
    logic [LANE_W-1:0]     base_q;
    lanes_t                offs_q;
    lanes_t                mask_q;
    logic [GR_IDX_W-1:0]   gr_q;
    logic                  pend_vld_q;
    logic                  pend_act_q;
    logic [LANE_IDX_W-1:0] pend_lane_q;
    logic                  accept;
    logic                  act_now;
    logic [LANE_W-1:0]     full_addr;

    assign accept    = post_valid && !busy;
    assign act_now   = mask_q[ctr_q][LANE_W-1];
    assign full_addr = lane_addr(base_q, offs_q[ctr_q]);
    assign busy      = walking_q || pend_vld_q;
    assign ram_re    = walking_q && act_now;
    assign ram_raddr = full_addr[MEM_AW-1:0];
    assign clr_en    = accept;
    assign clr_idx   = post_gr;
    assign lane_we   = pend_vld_q && pend_act_q;
    assign lane_gr   = gr_q;
    assign lane_idx  = pend_lane_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            walking_q   <= 1'b0;
            ctr_q       <= '0;
            pend_vld_q  <= 1'b0;
            pend_act_q  <= 1'b0;
            pend_lane_q <= '0;
            post_done   <= 1'b0;
            base_q      <= '0;
            offs_q      <= '0;
            mask_q      <= '0;
            gr_q        <= '0;
        end else begin
            post_done   <= pend_vld_q && (pend_lane_q == LANE_IDX_W'(LANES-1));
            pend_vld_q  <= walking_q;
            pend_act_q  <= act_now;
            pend_lane_q <= ctr_q;
            if (accept) begin
                walking_q <= 1'b1;
                ctr_q     <= '0;
                base_q    <= post_base;
                offs_q    <= post_offs;
                gr_q      <= post_gr;
                mask_q    <= post_pred_en ? expand_pred(post_pred) : expand_pred('1);
            end else if (walking_q) begin
                ctr_q <= ctr_q + 1'b1;
                if (ctr_q == LANE_IDX_W'(LANES-1)) walking_q <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/gth_grfile.sv
module gth_grfile
    import gth_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  clr_en,
    input  logic [GR_IDX_W-1:0]   clr_idx,
    input  logic                  lane_we,
    input  logic [GR_IDX_W-1:0]   lane_gr,
    input  logic [LANE_IDX_W-1:0] lane_idx,
    input  logic [LANE_W-1:0]     lane_data,
    input  logic                  drain_valid,
    input  logic [GR_IDX_W-1:0]   drain_gr,
    input  drain_mode_e           drain_mode,
    output logic [VEC_W-1:0]      drain_vec,
    output logic                  drain_vld
);
    lanes_t gr_q [NUM_GR];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_GR; i++) gr_q[i] <= '0;
            drain_vec <= '0;
            drain_vld <= 1'b0;
        end else begin
            if (clr_en) gr_q[clr_idx] <= '0;
            if (lane_we) gr_q[lane_gr][lane_idx] <= lane_data;
            drain_vld <= drain_valid;
            if (drain_valid) drain_vec <= format_drain(gr_q[drain_gr], drain_mode);
        end
    end
endmodule

// File: rtl/gth_gather_top.sv
module gth_gather_top
    import gth_pkg::*;
#(
    parameter int MEM_AW = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                mem_we,
    input  logic [MEM_AW-1:0]   mem_waddr,
    input  logic [LANE_W-1:0]   mem_wdata,
    input  logic                post_valid,
    input  logic                post_pred_en,
    input  logic [LANE_W-1:0]   post_base,
    input  logic [VEC_W-1:0]    post_offs,
    input  logic [LANES-1:0]    post_pred,
    input  logic [GR_IDX_W-1:0] post_gr,
    output logic                busy,
    output logic                post_done,
    input  logic                drain_valid,
    input  logic [GR_IDX_W-1:0] drain_gr,
    input  logic [1:0]          drain_mode,
    output logic [VEC_W-1:0]    drain_vec,
    output logic                drain_vld
);
    lanes_t                offs_l;
    logic                  ram_re;
    logic [MEM_AW-1:0]     ram_raddr;
    logic [LANE_W-1:0]     ram_rdata;
    logic                  clr_en;
    logic [GR_IDX_W-1:0]   clr_idx;
    logic                  lane_we;
    logic [GR_IDX_W-1:0]   lane_gr;
    logic [LANE_IDX_W-1:0] lane_idx;

    assign offs_l = post_offs;

    gth_seq #(.MEM_AW(MEM_AW)) seq_i (
        .clk(clk), .rst(rst),
        .post_valid(post_valid), .post_pred_en(post_pred_en),
        .post_base(post_base), .post_offs(offs_l),
        .post_pred(post_pred), .post_gr(post_gr),
        .busy(busy), .post_done(post_done),
        .ram_re(ram_re), .ram_raddr(ram_raddr),
        .clr_en(clr_en), .clr_idx(clr_idx),
        .lane_we(lane_we), .lane_gr(lane_gr), .lane_idx(lane_idx)
    );

    gth_ram #(.AW(MEM_AW), .DW(LANE_W)) ram_i (
        .clk(clk), .we(mem_we), .waddr(mem_waddr), .wdata(mem_wdata),
        .re(ram_re), .raddr(ram_raddr), .rdata(ram_rdata)
    );

    gth_grfile grf_i (
        .clk(clk), .rst(rst),
        .clr_en(clr_en), .clr_idx(clr_idx),
        .lane_we(lane_we), .lane_gr(lane_gr), .lane_idx(lane_idx),
        .lane_data(ram_rdata),
        .drain_valid(drain_valid), .drain_gr(drain_gr),
        .drain_mode(drain_mode_e'(drain_mode)),
        .drain_vec(drain_vec), .drain_vld(drain_vld)
    );
endmodule

// File: rtl/gth_chk.sv
module gth_chk (
    input logic         clk,
    input logic         rst,
    input logic         post_valid,
    input logic         busy,
    input logic         post_done,
    input logic         drain_valid,
    input logic [1:0]   drain_mode,
    input logic [511:0] drain_vec,
    input logic         drain_vld
);
    p_done_after_busy_r9: assert property (@(posedge clk) disable iff (rst)
        post_done |-> (!busy && $past(busy)));

    p_done_single_r9: assert property (@(posedge clk) disable iff (rst)
        post_done |=> !post_done);

    p_accept_busy_r9: assert property (@(posedge clk) disable iff (rst)
        (post_valid && !busy) |=> busy);

    p_drain_lat_r6: assert property (@(posedge clk) disable iff (rst)
        drain_valid |=> drain_vld);

    p_drain_quiet_r6: assert property (@(posedge clk) disable iff (rst)
        !drain_valid |=> !drain_vld);

    p_sx8_ext_r7: assert property (@(posedge clk) disable iff (rst)
        (drain_valid && drain_mode == 2'd1) |=> (drain_vec[31:8] == {24{drain_vec[7]}}));

    p_dual_lo_r8: assert property (@(posedge clk) disable iff (rst)
        (drain_valid && drain_mode == 2'd2) |=> (drain_vec[511:256] == '0));

    p_dual_hi_r8: assert property (@(posedge clk) disable iff (rst)
        (drain_valid && drain_mode == 2'd3) |=> (drain_vec[255:0] == '0));

    p_reset_idle_r11: assert property (@(posedge clk)
        rst |=> (!busy && !post_done && !drain_vld));
endmodule

bind gth_gather_top gth_chk chk_i (
    .clk(clk), .rst(rst), .post_valid(post_valid), .busy(busy),
    .post_done(post_done), .drain_valid(drain_valid), .drain_mode(drain_mode),
    .drain_vec(drain_vec), .drain_vld(drain_vld)
);

// File: tb/gth_gather_top_tb_top.sv
module gth_gather_top_tb_top;
    localparam int AW = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         mem_we = 1'b0;
    logic [AW-1:0] mem_waddr = '0;
    logic [31:0]  mem_wdata = '0;
    logic         post_valid = 1'b0;
    logic         post_pred_en = 1'b0;
    logic [31:0]  post_base = '0;
    logic [511:0] post_offs = '0;
    logic [15:0]  post_pred = '0;
    logic [2:0]   post_gr = '0;
    logic         busy, post_done;
    logic         drain_valid = 1'b0;
    logic [2:0]   drain_gr = '0;
    logic [1:0]   drain_mode = '0;
    logic [511:0] drain_vec;
    logic         drain_vld;

    int checks = 0;
    int fails  = 0;

    logic [31:0]  mem_model [1 << AW];
    logic [511:0] gr_model  [8];
    logic [511:0] exp_q [$];
    string        tag_q [$];

    always #4 clk = ~clk;

    gth_gather_top #(.MEM_AW(AW)) dut_i (
        .clk(clk), .rst(rst), .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata),
        .post_valid(post_valid), .post_pred_en(post_pred_en), .post_base(post_base),
        .post_offs(post_offs), .post_pred(post_pred), .post_gr(post_gr),
        .busy(busy), .post_done(post_done),
        .drain_valid(drain_valid), .drain_gr(drain_gr), .drain_mode(drain_mode),
        .drain_vec(drain_vec), .drain_vld(drain_vld)
    );

    task automatic check(input string tag, input logic [511:0] act, input logic [511:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [511:0] fmt(input logic [511:0] g, input logic [1:0] m);
        logic [511:0] v = '0;
        for (int k = 0; k < 16; k++) begin
            case (m)
                2'd0: v[32*k +: 32] = g[32*k +: 32];
                2'd1: v[32*k +: 32] = {{24{g[32*k+7]}}, g[32*k +: 8]};
                2'd2: v[16*k +: 16] = {8'h00, g[32*k +: 8]};
                default: v[256 + 16*k +: 16] = {8'h00, g[32*k +: 8]};
            endcase
        end
        return v;
    endfunction

    // Monitor: pops the scoreboard whenever a drain result appears.
    always @(posedge clk) begin
        #2;
        if (drain_vld) begin
            if (exp_q.size() == 0) begin
                check("R6 unexpected drain_vld", 512'd1, 512'd0);
            end else begin
                logic [511:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(t, drain_vec, e);
            end
        end
    end

    task automatic do_drain(input logic [2:0] g, input logic [1:0] m, input string tag);
        @(negedge clk);
        drain_valid = 1'b1;
        drain_gr    = g;
        drain_mode  = m;
        exp_q.push_back(fmt(gr_model[g], m));
        tag_q.push_back(tag);
        @(negedge clk);
        drain_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic do_post(input logic pen, input logic [31:0] base, input logic [511:0] offs,
                           input logic [15:0] pred, input logic [2:0] g, input bit intrude);
        int cnt;
        logic [31:0] a;
        @(negedge clk);
        post_valid   = 1'b1;
        post_pred_en = pen;
        post_base    = base;
        post_offs    = offs;
        post_pred    = pred;
        post_gr      = g;
        gr_model[g]  = '0;
        for (int k = 0; k < 16; k++) begin
            a = base + offs[32*k +: 32];
            if (!pen || pred[k]) gr_model[g][32*k +: 32] = mem_model[a[AW-1:0]];
        end
        @(posedge clk); #2;
        post_valid = 1'b0;
        cnt = 0;
        while (busy && cnt < 40) begin
            cnt++;
            if (intrude && cnt == 3) begin
                post_valid = 1'b1; post_pred_en = 1'b0; post_gr = 3'd7; post_base = 32'h55;
            end
            if (intrude && cnt == 4) post_valid = 1'b0;
            @(posedge clk); #2;
        end
        check(intrude ? "R10 busy length with intrusion" : "R9 busy length", 512'(cnt), 512'd17);
        check("R9 post_done after busy", {511'd0, post_done}, 512'd1);
        @(posedge clk); #2;
        check("R9 post_done single pulse", {510'd0, post_done, busy}, 512'd0);
    endtask

    function automatic logic [511:0] mk_offs(input int mul, input int add);
        logic [511:0] o;
        for (int k = 0; k < 16; k++) o[32*k +: 32] = 32'(k * mul + add);
        return o;
    endfunction

    initial begin
        #(8 * 150000);
        fails++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < 8; i++) gr_model[i] = '0;
        for (int i = 0; i < (1 << AW); i++) mem_model[i] = 32'(i + 1) * 32'h9E3779B9;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(posedge clk); #2;
        // R11: idle outputs after reset
        check("R11 reset outputs", {509'd0, busy, post_done, drain_vld}, 512'd0);
        do_drain(3'd3, 2'd0, "R11 register zero after reset");

        for (int i = 0; i < (1 << AW); i++) begin
            @(negedge clk);
            mem_we = 1'b1; mem_waddr = AW'(i); mem_wdata = mem_model[i];
        end
        @(negedge clk);
        mem_we = 1'b0;

        // R2 R3 R4: predicated gather, mixed lanes
        do_post(1'b1, 32'h10, mk_offs(3, 0), 16'hA5C3, 3'd0, 1'b0);
        do_drain(3'd0, 2'd0, "R3 R4 R6 predicated gather gr0");

        // R2: address wraps modulo 2^32
        do_post(1'b1, 32'hFFFF_FFF0, mk_offs(7, 5), 16'hFFFF, 3'd5, 1'b0);
        do_drain(3'd5, 2'd0, "R2 wrapped addresses gr5");

        // R5: non-predicated form ignores predicate
        do_post(1'b0, 32'h0000_0100, mk_offs(11, 2), 16'h0000, 3'd2, 1'b0);
        do_drain(3'd2, 2'd0, "R5 non-predicated all lanes gr2");

        // R4: killed lanes cleared although gr0 held data
        do_post(1'b1, 32'h40, mk_offs(5, 1), 16'h0F0F, 3'd0, 1'b0);
        do_drain(3'd0, 2'd0, "R4 killed lanes zeroed on reuse gr0");

        // R7 R8: sub-width drains
        do_drain(3'd5, 2'd1, "R7 sign-extend byte gr5");
        do_drain(3'd2, 2'd1, "R7 sign-extend byte gr2");
        do_drain(3'd2, 2'd2, "R8 dual low half gr2");
        do_drain(3'd2, 2'd3, "R8 dual high half gr2");

        // R1: other registers unchanged
        do_drain(3'd5, 2'd0, "R1 gr5 intact after later posts");
        do_drain(3'd1, 2'd0, "R1 gr1 never posted stays zero");

        // R10: post_valid during busy is ignored
        do_post(1'b1, 32'h80, mk_offs(1, 0), 16'h3CF0, 3'd6, 1'b1);
        do_drain(3'd6, 2'd0, "R10 running post unaffected gr6");
        do_drain(3'd7, 2'd0, "R10 ignored post left gr7 zero");

        repeat (4) @(negedge clk);
        check("R6 scoreboard drained", 512'(exp_q.size()), 512'd0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule